// File: doc/BRIEF.md
# Register Rename Map with Free List

This block renames one instruction per cycle of the form `dst <- src1 op src2`, translating logical register numbers into physical register tags. A map table indexed by logical register gives the current physical tag of each source. A queue of unused physical tags supplies the new destination tag. A ready bit per physical register tells the scheduler whether each source value already exists.

A rename is accepted when `ren_valid` is high and `ren_stall` is low. On the following clock edge the destination's map entry takes the tag at the head of the free queue, the head advances, and that tag's ready bit is cleared. A completion port marks a physical register ready. A release port hands a retired tag back to the tail of the queue. The previous mapping of the destination is output, so that a later commit stage can return it through the release port.

Every output is combinational from the stored state and the current inputs. Sources and the previous mapping are therefore read before the current instruction's own map update takes effect.

Top module: `rename_map`

## Requirements
- R1: After reset, logical register n maps to physical tag n, and the free queue holds tags 32 to 63 with 32 at the head. Every physical register is ready, and `ren_stall` is 0.
- R2: `dst_tag` shows the head of the free queue. An accepted rename writes that tag into the destination's map entry and advances the head, so successive renames receive successive queue entries.
- R3: A newly allocated tag has its ready bit cleared on the allocating edge. A later source that maps to it reports ready 0 until it completes.
- R4: `ren_stall` is 1 exactly when the free queue is empty. While it is 1, `ren_valid` changes no map entry and does not move the queue head.
- R5: A completion of tag t (`cmp_valid`=1) sets the ready bit of t from the next cycle onward.
- R6: A released tag is appended at the queue tail and is handed out in first-in, first-out order. A release and an allocation in the same cycle leave the queue occupancy unchanged.
- R7: Source lookups use the map state from before the current instruction's destination update. An instruction that reads and writes the same logical register therefore receives the old tag for its sources.
- R8: `prev_tag` equals the physical tag currently mapped to `ren_dst`.
- R9: A completion in the same cycle as a lookup of the same tag makes that source's ready output 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request |
| ren_src1 | input | 5 | Logical source 1 |
| ren_src2 | input | 5 | Logical source 2 |
| ren_dst | input | 5 | Logical destination |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | 6 | Physical tag that completed |
| rel_valid | input | 1 | Release strobe |
| rel_tag | input | 6 | Physical tag returned to the free queue |
| ren_stall | output | 1 | Free queue empty; rename not accepted |
| src1_tag | output | 6 | Physical tag of source 1 |
| src1_rdy | output | 1 | Source 1 value is available |
| src2_tag | output | 6 | Physical tag of source 2 |
| src2_rdy | output | 1 | Source 2 value is available |
| dst_tag | output | 6 | New physical tag for the destination |
| prev_tag | output | 6 | Prior physical tag of the destination |

## Verification
Two pairs of functions can coincide in one cycle.

The first pair is a completion and a source lookup of the same tag. The bench drives `cmp_tag` equal to a pending source's tag in the same cycle as the lookup. It expects that source's ready output to be 1 at once, while the other, still pending source stays at 0.

The second pair is a release and an allocation when only one tag is free. The bench then expects the stall to stay low afterwards, and the released tag to appear as the next `dst_tag`.

// File: rtl/rename_map.sv
module rename_map #(
  parameter int LOG_REGS  = 32,
  parameter int PHYS_REGS = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ren_valid,
  input  logic [$clog2(LOG_REGS)-1:0]  ren_src1,
  input  logic [$clog2(LOG_REGS)-1:0]  ren_src2,
  input  logic [$clog2(LOG_REGS)-1:0]  ren_dst,
  input  logic                         cmp_valid,
  input  logic [$clog2(PHYS_REGS)-1:0] cmp_tag,
  input  logic                         rel_valid,
  input  logic [$clog2(PHYS_REGS)-1:0] rel_tag,
  output logic                         ren_stall,
  output logic [$clog2(PHYS_REGS)-1:0] src1_tag,
  output logic                         src1_rdy,
  output logic [$clog2(PHYS_REGS)-1:0] src2_tag,
  output logic                         src2_rdy,
  output logic [$clog2(PHYS_REGS)-1:0] dst_tag,
  output logic [$clog2(PHYS_REGS)-1:0] prev_tag
);
  localparam int PW       = $clog2(PHYS_REGS);
  localparam int FL_DEPTH = PHYS_REGS - LOG_REGS;
  localparam int FW       = (FL_DEPTH > 1) ? $clog2(FL_DEPTH) : 1;
  localparam int CW       = $clog2(FL_DEPTH + 1);

  logic [PW-1:0]        map_q [LOG_REGS];
  logic [PW-1:0]        fl_q  [FL_DEPTH];
  logic [PHYS_REGS-1:0] rdy_q;
  logic [FW-1:0]        fl_head, fl_tail;
  logic [CW-1:0]        fl_count;

  wire fire = ren_valid && !ren_stall;

  assign ren_stall = (fl_count == '0);
  assign src1_tag  = map_q[ren_src1];
  assign src2_tag  = map_q[ren_src2];
  assign prev_tag  = map_q[ren_dst];
  assign dst_tag   = fl_q[fl_head];
  assign src1_rdy  = rdy_q[src1_tag] | (cmp_valid && cmp_tag == src1_tag);
  assign src2_rdy  = rdy_q[src2_tag] | (cmp_valid && cmp_tag == src2_tag);

  function automatic logic [FW-1:0] wrap_inc(input logic [FW-1:0] p);
    return (p == FW'(FL_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LOG_REGS; i++) map_q[i] <= PW'(i);
      for (int i = 0; i < FL_DEPTH; i++) fl_q[i] <= PW'(LOG_REGS + i);
      rdy_q    <= '1;
      fl_head  <= '0;
      fl_tail  <= '0;
      fl_count <= CW'(FL_DEPTH);
    end else begin
      if (cmp_valid) rdy_q[cmp_tag] <= 1'b1;
      if (fire) begin
        map_q[ren_dst] <= dst_tag;
        rdy_q[dst_tag] <= 1'b0;
        fl_head        <= wrap_inc(fl_head);
      end
      if (rel_valid) begin
        fl_q[fl_tail] <= rel_tag;
        fl_tail       <= wrap_inc(fl_tail);
      end
      if (fire && !rel_valid)      fl_count <= fl_count - 1'b1;
      else if (!fire && rel_valid) fl_count <= fl_count + 1'b1;
    end
  end

  a_r2_map_written: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> map_q[$past(ren_dst)] == $past(dst_tag));

  a_r2_head_moves: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> fl_head != $past(fl_head) || FL_DEPTH == 1);

  a_r3_alloc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(cmp_valid && cmp_tag == dst_tag)) |=> !rdy_q[$past(dst_tag)]);

  a_r4_stall_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ren_stall |=> $stable(fl_head));

  a_r5_complete_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !(fire && dst_tag == cmp_tag)) |=> rdy_q[$past(cmp_tag)]);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fl_count <= CW'(FL_DEPTH));
endmodule

// File: tb/rename_map_tb.sv
module rename_map_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ren_valid = 0, cmp_valid = 0, rel_valid = 0;
  logic [4:0] ren_src1 = 0, ren_src2 = 0, ren_dst = 0;
  logic [5:0] cmp_tag = 0, rel_tag = 0;
  logic ren_stall, src1_rdy, src2_rdy;
  logic [5:0] src1_tag, src2_tag, dst_tag, prev_tag;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rename_map u_dut (.*);

  task automatic chk(input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic drive(input bit v, input int s1, input int s2, input int d,
                       input bit cv, input int ct, input bit rv, input int rt);
    ren_valid = v; ren_src1 = 5'(s1); ren_src2 = 5'(s2); ren_dst = 5'(d);
    cmp_valid = cv; cmp_tag = 6'(ct); rel_valid = rv; rel_tag = 6'(rt);
    #2;
  endtask

  task automatic commit;
    @(negedge clk);
    ren_valid = 0; cmp_valid = 0; rel_valid = 0;
  endtask

  task automatic t_reset;
    drive(0, 5, 31, 3, 0, 0, 0, 0);
    chk("R1 src1 identity", src1_tag, 5);
    chk("R1 src1 ready", src1_rdy, 1);
    chk("R1 src2 identity", src2_tag, 31);
    chk("R1 first free", dst_tag, 32);
    chk("R1 no stall", ren_stall, 0);
    chk("R8 prev at reset", prev_tag, 3);
  endtask

  task automatic t_basic;
    drive(1, 2, 3, 1, 0, 0, 0, 0);
    chk("R2 dst tag", dst_tag, 32);
    chk("R8 prev", prev_tag, 1);
    commit();
    drive(1, 1, 5, 4, 0, 0, 0, 0);
    chk("R2 remap seen", src1_tag, 32);
    chk("R3 not ready", src1_rdy, 0);
    chk("R2 head advanced", dst_tag, 33);
    chk("R8 prev r4", prev_tag, 4);
    commit();
  endtask

  task automatic t_same_reg;
    drive(1, 5, 5, 5, 0, 0, 0, 0);
    chk("R7 src1 old", src1_tag, 5);
    chk("R7 src2 old", src2_tag, 5);
    chk("R7 prev old", prev_tag, 5);
    chk("R2 dst", dst_tag, 34);
    commit();
    drive(0, 5, 0, 0, 0, 0, 0, 0);
    chk("R7 new map", src1_tag, 34);
  endtask

  task automatic t_complete;
    drive(0, 1, 4, 0, 1, 32, 0, 0);
    chk("R9 forwarded ready", src1_rdy, 1);
    chk("R9 other pending", src2_rdy, 0);
    commit();
    drive(0, 1, 4, 0, 0, 0, 0, 0);
    chk("R5 ready held", src1_rdy, 1);
    chk("R5 unrelated pending", src2_rdy, 0);
  endtask

  task automatic t_exhaust;
    for (int i = 0; i < 29; i++) begin
      drive(1, 0, 0, 8, 0, 0, 0, 0);
      chk("R2 sequential alloc", dst_tag, 35 + i);
      commit();
    end
    drive(1, 8, 9, 9, 0, 0, 0, 0);
    chk("R4 stall when empty", ren_stall, 1);
    chk("R2 last map", src1_tag, 63);
    commit();
    drive(0, 9, 0, 0, 0, 0, 0, 0);
    chk("R4 map unchanged", src1_tag, 9);
    chk("R4 still stalled", ren_stall, 1);
  endtask

  task automatic t_release;
    drive(0, 0, 0, 0, 0, 0, 1, 1);
    commit();
    drive(1, 0, 0, 7, 0, 0, 1, 4);
    chk("R6 unstalled", ren_stall, 0);
    chk("R6 released tag out", dst_tag, 1);
    chk("R8 prev r7", prev_tag, 7);
    commit();
    drive(0, 7, 0, 0, 0, 0, 0, 0);
    chk("R6 occupancy kept", ren_stall, 0);
    chk("R6 fifo order", dst_tag, 4);
    chk("R2 reuse mapped", src1_tag, 1);
    chk("R3 reused not ready", src1_rdy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_same_reg();
    t_complete();
    t_exhaust();
    t_release();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule